// File: doc/BRIEF.md
# Programmable-Priority Bus Arbiter with Tenure Timer

This block is the central arbiter for a shared parallel bus with four masters. Each master has one request line and one grant line. Each master also has a static priority level that a host scheduler can rewrite at any time through a small register write port. When the bus is free, the arbiter gives the grant to the active requester with the largest priority value. A master must win arbitration again for every access. By default the levels follow rate-monotonic order: master 0 is the most urgent and master 3 the least.

A master that holds the grant is never preempted before its tenure expires. A tenure counter runs while the master owns the bus. When the count reaches the programmed limit and some other master is requesting, the grant is withdrawn. If nobody else is waiting, the owner keeps the bus. An owner that finishes early drops its request and loses the grant at once. Every handover passes through exactly one cycle with no grant. A small limit therefore gives short tenures and frequent re-arbitration, and a large limit gives long blocking of urgent masters. For each master, a saturating counter measures how many cycles it waited behind a less urgent owner, so software can see the blocking that a chosen limit causes.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset no grant is asserted, the priority levels of masters 0..3 are 3, 2, 1, 0, the tenure limit is LIMIT_RST (16), and every blocking counter reads zero.
- R2: At most one grant bit is asserted in any cycle.
- R3: When no grant is asserted and at least one request is sampled at a clock edge, the grant goes to a requester after that edge. The winner is the requester with the numerically largest priority value. Among equal values, the lowest master index wins.
- R4: Grant bit i corresponds to request bit i and to master i.
- R5: If the owner's request is low at a clock edge, its grant is low after that edge.
- R6: With tenure limit L ≥ 1 latched at grant time, a still-requesting owner holds the grant for exactly L cycles when another master is requesting. A limit of 0 behaves like 1.
- R7: If no other master requests when the tenure count reaches the limit, the owner keeps the grant while it keeps requesting.
- R8: A request from a more urgent master never removes the grant before the owner's tenure count reaches its limit.
- R9: A grant never moves directly from one master to another. At least one cycle with no grant separates two owners, and when requests are pending it is exactly one cycle.
- R10: A write with cfg_addr_i = i (0..3) sets master i's priority to cfg_wdata_i[3:0]. A write with cfg_addr_i = 4 sets the 8-bit tenure limit. Writes to addresses 5..7 are ignored. A priority write affects only later arbitration decisions, and a limit write does not change a tenure already in progress.
- R11: Blocking counter i increments once per clock edge at which master i requests, another master owns the grant, and the owner loses to master i under the R3 ordering. The counter saturates at its maximum. It is read on blk_cnt_o when blk_sel_i = i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Request line per master |
| gnt_o | output | N_MST | Grant line per master, one-hot or zero |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration target: 0..N_MST-1 priority, N_MST tenure limit |
| cfg_wdata_i | input | TEN_W | Configuration write data |
| blk_sel_i | input | IDX_W | Selects which blocking counter is read |
| blk_cnt_o | output | BLK_W | Selected blocking counter value |

## Verification
A grant appears one clock after a request is sampled on an idle bus. A release, whether from an early request drop or from an expired tenure, clears the grant one clock after the deciding edge. The next owner follows one clock after that. Configuration writes and blocking-counter increments take effect at the same edge that samples them, and blk_cnt_o follows blk_sel_i without delay. The bench drives inputs on falling edges and checks the directed expectations at the next falling edge, which is one registered stage later. A behavioural model, stepped on every rising edge with the same sampled inputs, is compared with gnt_o and blk_cnt_o a few nanoseconds after each rising edge.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_OWN  = 1'b1
  } arb_state_e;
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs #(
  parameter int unsigned N_MST     = 4,
  parameter int unsigned PRIO_W    = 4,
  parameter int unsigned TEN_W     = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned LIMIT_RST = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cfg_we_i,
  input  logic [ADDR_W-1:0]                cfg_addr_i,
  input  logic [TEN_W-1:0]                 cfg_wdata_i,
  output logic [N_MST-1:0][PRIO_W-1:0]     prio_o,
  output logic [TEN_W-1:0]                 limit_o
);
  localparam logic [ADDR_W-1:0] LIMIT_ADDR = ADDR_W'(N_MST);

  // rate-monotonic default: master 0 most urgent
  for (genvar g = 0; g < N_MST; g++) begin : g_prio
    localparam logic [PRIO_W-1:0] RST_VAL = PRIO_W'(N_MST - 1 - g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_o[g] <= RST_VAL;
      end else if (cfg_we_i && cfg_addr_i == ADDR_W'(g)) begin
        prio_o[g] <= cfg_wdata_i[PRIO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_o <= TEN_W'(LIMIT_RST);
    end else if (cfg_we_i && cfg_addr_i == LIMIT_ADDR) begin
      limit_o <= cfg_wdata_i;
    end
  end
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int unsigned N_MST  = 4,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [N_MST-1:0]             req_i,
  input  logic [N_MST-1:0][PRIO_W-1:0] prio_i,
  output logic                         win_vld_o,
  output logic [IDX_W-1:0]             win_idx_o
);
  logic              found;
  logic [IDX_W-1:0]  idx;
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lower index on ties
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N_MST; i++) begin
      if (req_i[i] && (!found || prio_i[i] > best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = prio_i[i];
      end
    end
  end

  assign win_vld_o = found;
  assign win_idx_o = idx;
endmodule

// File: rtl/arb_tenure_fsm.sv
module arb_tenure_fsm
  import prio_arb_pkg::*;
#(
  parameter int unsigned N_MST = 4,
  parameter int unsigned TEN_W = 8,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] req_i,
  input  logic             win_vld_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic [TEN_W-1:0] limit_i,
  output logic [N_MST-1:0] gnt_o,
  output logic             own_vld_o,
  output logic [IDX_W-1:0] own_idx_o,
  output logic [TEN_W-1:0] ten_cnt_o,
  output logic [TEN_W-1:0] ten_lim_o
);
  arb_state_e       state_q, state_d;
  logic [IDX_W-1:0] own_q, own_d;
  logic [TEN_W-1:0] cnt_q, cnt_d;
  logic [TEN_W-1:0] lim_q, lim_d;
  logic [N_MST-1:0] own_oh;
  logic             own_req;
  logic             others;
  logic             expired;

  assign own_oh  = N_MST'(1) << own_q;
  assign own_req = |(req_i & own_oh);
  assign others  = |(req_i & ~own_oh);
  assign expired = (cnt_q >= lim_q);

  always_comb begin
    state_d = state_q;
    own_d   = own_q;
    cnt_d   = cnt_q;
    lim_d   = lim_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (win_vld_i) begin
          state_d = ARB_OWN;
          own_d   = win_idx_i;
          cnt_d   = TEN_W'(1);
          lim_d   = limit_i;  // latched: later writes wait for next tenure
        end
      end
      ARB_OWN: begin
        if (!own_req || (expired && others)) begin
          state_d = ARB_IDLE;  // idle cycle doubles as arbitration slot
        end else if (cnt_q != '1) begin
          cnt_d = cnt_q + TEN_W'(1);
        end
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_IDLE;
      own_q   <= '0;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else begin
      state_q <= state_d;
      own_q   <= own_d;
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
    end
  end

  assign own_vld_o = (state_q == ARB_OWN);
  assign own_idx_o = own_q;
  assign gnt_o     = own_vld_o ? own_oh : '0;
  assign ten_cnt_o = cnt_q;
  assign ten_lim_o = lim_q;
endmodule

// File: rtl/arb_block_cnt.sv
module arb_block_cnt #(
  parameter int unsigned N_MST  = 4,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned BLK_W  = 16,
  parameter int unsigned IDX_W  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_MST-1:0]             req_i,
  input  logic [N_MST-1:0][PRIO_W-1:0] prio_i,
  input  logic                         own_vld_i,
  input  logic [IDX_W-1:0]             own_idx_i,
  output logic [N_MST-1:0][BLK_W-1:0]  cnt_o
);
  logic [PRIO_W-1:0] own_prio;
  assign own_prio = prio_i[own_idx_i];

  for (genvar g = 0; g < N_MST; g++) begin : g_cnt
    logic outranks;
    logic hit;

    always_comb begin
      outranks = (prio_i[g] > own_prio) ||
                 ((prio_i[g] == own_prio) && (IDX_W'(g) < own_idx_i));
      hit      = req_i[g] && own_vld_i && (own_idx_i != IDX_W'(g)) && outranks;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_o[g] <= '0;
      end else if (hit && cnt_o[g] != '1) begin
        cnt_o[g] <= cnt_o[g] + BLK_W'(1);
      end
    end
  end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter  int unsigned N_MST     = 4,
  parameter  int unsigned PRIO_W    = 4,
  parameter  int unsigned TEN_W     = 8,
  parameter  int unsigned BLK_W     = 16,
  parameter  int unsigned LIMIT_RST = 16,
  localparam int unsigned IDX_W     = $clog2(N_MST),
  localparam int unsigned ADDR_W    = $clog2(N_MST + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_MST-1:0]  req_i,
  output logic [N_MST-1:0]  gnt_o,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [TEN_W-1:0]  cfg_wdata_i,
  input  logic [IDX_W-1:0]  blk_sel_i,
  output logic [BLK_W-1:0]  blk_cnt_o
);
  logic [N_MST-1:0][PRIO_W-1:0] prio;
  logic [TEN_W-1:0]             limit;
  logic                         win_vld;
  logic [IDX_W-1:0]             win_idx;
  logic                         own_vld;
  logic [IDX_W-1:0]             own_idx;
  logic [TEN_W-1:0]             ten_cnt;
  logic [TEN_W-1:0]             ten_lim;
  logic [N_MST-1:0][BLK_W-1:0]  blk_q;

  arb_cfg_regs #(
    .N_MST(N_MST), .PRIO_W(PRIO_W), .TEN_W(TEN_W),
    .ADDR_W(ADDR_W), .LIMIT_RST(LIMIT_RST)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .prio_o     (prio),
    .limit_o    (limit)
  );

  arb_pick #(
    .N_MST(N_MST), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
  ) u_pick (
    .req_i    (req_i),
    .prio_i   (prio),
    .win_vld_o(win_vld),
    .win_idx_o(win_idx)
  );

  arb_tenure_fsm #(
    .N_MST(N_MST), .TEN_W(TEN_W), .IDX_W(IDX_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .win_vld_i(win_vld),
    .win_idx_i(win_idx),
    .limit_i  (limit),
    .gnt_o    (gnt_o),
    .own_vld_o(own_vld),
    .own_idx_o(own_idx),
    .ten_cnt_o(ten_cnt),
    .ten_lim_o(ten_lim)
  );

  arb_block_cnt #(
    .N_MST(N_MST), .PRIO_W(PRIO_W), .BLK_W(BLK_W), .IDX_W(IDX_W)
  ) u_blk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .prio_i   (prio),
    .own_vld_i(own_vld),
    .own_idx_i(own_idx),
    .cnt_o    (blk_q)
  );

  assign blk_cnt_o = blk_q[blk_sel_i];
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk #(
  parameter int unsigned N_MST = 4,
  parameter int unsigned TEN_W = 8,
  parameter int unsigned BLK_W = 16,
  parameter int unsigned IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] req_i,
  input logic [N_MST-1:0] gnt_o,
  input logic [IDX_W-1:0] blk_sel_i,
  input logic [BLK_W-1:0] blk_cnt_o,
  input logic [TEN_W-1:0] ten_cnt_i,
  input logic [TEN_W-1:0] ten_lim_i
);
  // R2
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R3
  idle_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0 && req_i != '0) |=> (gnt_o != '0 && (gnt_o & $past(req_i)) == gnt_o));

  // R5
  early_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && (gnt_o & req_i) == '0) |=> gnt_o == '0);

  // R7
  lone_owner_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && req_i == gnt_o) |=> gnt_o == $past(gnt_o));

  // R8
  no_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && (gnt_o & req_i) != '0 && ten_cnt_i < ten_lim_i) |=> gnt_o == $past(gnt_o));

  // R9
  handover_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |=> (gnt_o == '0 || gnt_o == $past(gnt_o)));

  // R11
  blk_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(blk_sel_i) |-> blk_cnt_o >= $past(blk_cnt_o));
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(
  .N_MST(N_MST), .TEN_W(TEN_W), .BLK_W(BLK_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .gnt_o    (gnt_o),
  .blk_sel_i(blk_sel_i),
  .blk_cnt_o(blk_cnt_o),
  .ten_cnt_i(ten_cnt),
  .ten_lim_i(ten_lim)
);

// File: tb/prio_bus_arbiter_tb_top.sv
module prio_bus_arbiter_tb_top;
  localparam int BW   = 6;
  localparam int BMAX = (1 << BW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req;
  logic [3:0] gnt;
  logic       we;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [1:0] sel;
  logic [BW-1:0] blk;

  always #10 clk = ~clk;  // 20 ns period

  prio_bus_arbiter #(.BLK_W(BW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gnt_o(gnt),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .blk_sel_i(sel), .blk_cnt_o(blk)
  );

  int    total = 0;
  int    bad   = 0;
  string tag   = "R1";

  // behavioural reference
  int m_own, m_cnt, m_lim, m_limit;
  int m_prio[4];
  int m_blk[4];

  function automatic bit outranks(int a, int b);
    return (m_prio[a] > m_prio[b]) || (m_prio[a] == m_prio[b] && a < b);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own = -1; m_cnt = 0; m_lim = 0; m_limit = 16;
      for (int i = 0; i < 4; i++) begin
        m_prio[i] = 3 - i;
        m_blk[i]  = 0;
      end
    end else begin
      int  w;
      bit  oth;
      if (m_own >= 0)
        for (int i = 0; i < 4; i++)
          if (req[i] && i != m_own && outranks(i, m_own) && m_blk[i] < BMAX) m_blk[i]++;
      if (m_own < 0) begin
        w = -1;
        for (int i = 0; i < 4; i++)
          if (req[i] && (w < 0 || m_prio[i] > m_prio[w])) w = i;
        if (w >= 0) begin m_own = w; m_cnt = 1; m_lim = m_limit; end
      end else begin
        oth = 1'b0;
        for (int i = 0; i < 4; i++) if (i != m_own && req[i]) oth = 1'b1;
        if (!req[m_own]) m_own = -1;
        else if (m_cnt >= m_lim && oth) m_own = -1;
        else if (m_cnt < 255) m_cnt++;
      end
      if (we) begin
        if (addr < 4) m_prio[addr] = int'(wdata[3:0]);
        else if (addr == 4) m_limit = int'(wdata);
      end
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", t, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the edge
  always begin
    @(posedge clk);
    #5;
    if (rst_n) begin
      chk({tag, " gnt vs model"}, {28'd0, gnt}, (m_own < 0) ? 32'd0 : (32'd1 << m_own));
      chk({tag, " blk vs model"}, {26'd0, blk}, m_blk[sel]);
      chk("R2 onehot", {31'd0, ($countones(gnt) <= 1)}, 32'd1);
    end
  end

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    we = 1'b1; addr = 3'(a); wdata = 8'(d);
    nx();
    we = 1'b0;
  endtask

  task automatic rd_blk(int i, int exp, string t);
    sel = 2'(i);
    #1;
    chk(t, {26'd0, blk}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    req = '0; we = 1'b0; addr = '0; wdata = '0; sel = '0;
    repeat (3) nx();
    rst_n = 1'b1;
    nx();

    // R1 reset state
    chk("R1 gnt", {28'd0, gnt}, 0);
    for (int i = 0; i < 4; i++) rd_blk(i, 0, "R1 blk");

    // R3 R4 default order, R5 early release
    tag = "R3";
    req = 4'b1111; nx(); chk("R3 R4 default winner", {28'd0, gnt}, 1);
    req = 4'b0000; nx(); chk("R5 release on drop", {28'd0, gnt}, 0);

    // R3 tie -> lower index
    wr(0, 5); wr(1, 5); wr(2, 5); wr(3, 5);
    req = 4'b1100; nx(); chk("R3 tie winner", {28'd0, gnt}, 4);
    req = 4'b0000; nx(); chk("R5 release", {28'd0, gnt}, 0);
    wr(0, 3); wr(1, 2); wr(2, 1); wr(3, 0);

    // R6 tenure of 3, R9 single gap
    tag = "R6";
    wr(4, 3);
    req = 4'b0110; nx();
    for (int k = 0; k < 3; k++) begin chk("R6 tenure hold", {28'd0, gnt}, 2); nx(); end
    chk("R9 gap after expiry", {28'd0, gnt}, 0);
    req = 4'b0100; nx(); chk("R9 next owner after one gap", {28'd0, gnt}, 4);
    req = 4'b0000; nx();

    // R7 lone owner keeps bus past limit
    tag = "R7";
    req = 4'b1000; nx();
    for (int k = 0; k < 8; k++) begin chk("R7 lone owner", {28'd0, gnt}, 8); nx(); end
    req = 4'b0000; nx();

    // R8 no preemption, R11 blocking count
    tag = "R8";
    req = 4'b1000; nx(); chk("R8 owner", {28'd0, gnt}, 8);
    req = 4'b1001; nx(); chk("R8 held", {28'd0, gnt}, 8);
    nx(); chk("R8 held", {28'd0, gnt}, 8);
    nx(); chk("R9 gap", {28'd0, gnt}, 0);
    rd_blk(0, 3, "R11 blocked cycles");
    nx(); chk("R3 urgent wins after gap", {28'd0, gnt}, 1);
    req = 4'b0000; nx();

    // R10 limit write mid-tenure is deferred
    tag = "R10";
    req = 4'b0001; nx(); chk("R10 owner", {28'd0, gnt}, 1);
    req = 4'b0011; we = 1'b1; addr = 3'd4; wdata = 8'd1; nx(); we = 1'b0;
    chk("R10 latched limit", {28'd0, gnt}, 1);
    nx(); chk("R10 latched limit", {28'd0, gnt}, 1);
    nx(); chk("R10 expiry at old limit", {28'd0, gnt}, 0);
    req = 4'b0010; nx(); chk("R10 new tenure", {28'd0, gnt}, 2);
    nx(); chk("R7 limit 1 uncontested", {28'd0, gnt}, 2);
    req = 4'b0000; nx();

    // R10 priority rewrite and ignored addresses
    wr(4, 4); wr(3, 7); wr(0, 0); wr(6, 1); wr(5, 2); wr(7, 0);
    req = 4'b1001; nx(); chk("R10 new priority winner", {28'd0, gnt}, 8);
    for (int k = 0; k < 3; k++) begin nx(); chk("R10 limit 4 untouched", {28'd0, gnt}, 8); end
    nx(); chk("R10 gap", {28'd0, gnt}, 0);
    nx(); chk("R10 winner again", {28'd0, gnt}, 8);
    rd_blk(0, 3, "R11 no count behind more urgent owner");
    req = 4'b0000; nx();
    wr(0, 3); wr(3, 0); wr(4, 255);

    // R11 saturation
    tag = "R11";
    req = 4'b0100; nx(); chk("R11 owner", {28'd0, gnt}, 4);
    req = 4'b0101;
    repeat (80) nx();
    rd_blk(0, BMAX, "R11 saturated");
    chk("R8 long tenure held", {28'd0, gnt}, 4);
    req = 4'b0000; nx(); nx();

    // mixed traffic against model
    tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < 4; b++) if ($urandom_range(3) == 0) req[b] = ~req[b];
      if ($urandom_range(15) == 0) begin
        we = 1'b1;
        addr = 3'($urandom_range(7));
        wdata = (addr == 3'd4) ? 8'($urandom_range(5)) : 8'($urandom);
      end else begin
        we = 1'b0;
      end
      sel = 2'($urandom_range(3));
      nx();
    end
    we = 1'b0; req = '0;
    nx(); nx();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule